// File: doc/BRIEF.md
# Double-Buffered Transmit Bit Serializer

This block sits between a host processor and a bit-serial modulator. The host fills two alternating transmit buffers through a byte-wide write/read port. Each buffer holds up to eight data bytes and one status byte that carries the byte count. The modulator pulls bits one at a time with a request strobe. On each request the block returns the next bit of the stream: the lowest bit of each byte goes first, and the bytes go in increasing index order.

When the internal shift register runs dry on a request, the block looks at the status byte of the current buffer. A valid count loads that buffer and clears its status byte. The block then pulses the buffer-emptied interrupt and switches to the other buffer. A zero count is an underflow: the block sets a sticky error, pulses the error interrupt and points back at buffer 0. A malformed status byte is left in place and reported as a format error.

While transmission is disabled, or while the underflow error is set, the line idles at logic 1. A request to disable takes effect only after both status bytes read zero and the last loaded bit has been sent. A stop therefore never cuts a buffer short.

Top module: `txbuf_serializer`

## Requirements
- R1: The host port addresses 18 byte locations. Address 0 is the status byte of buffer 0 and addresses 1..8 are its data bytes 0..7. Address 9 is the status byte of buffer 1 and addresses 10..17 are its data bytes 0..7. A write at the rising edge with `host_we` high stores `host_wdata`, and `host_rdata` returns the addressed byte without delay.
- R2: A status byte with bits 7..4 zero and bits 3..0 equal to n (1..8) sends exactly 8n bits: byte 0 first, then byte 1 and so on, bit 0 first within each byte. Each bit appears on `tx_bit` after the clock edge at which its `bit_req` is sampled, and holds until the next request.
- R3: When a buffer is loaded, its status byte reads 0 afterwards. `buf_irq` is high for exactly the one cycle that follows the request that caused the load.
- R4: The buffer index starts at 0 after reset and changes buffer on every load, giving 0, 1, 0, 1 and so on.
- R5: While transmission is inactive, including after reset, `tx_bit` is 1 and requests consume nothing.
- R6: A request made when the shift register is empty and the current status byte is 0 sets `underflow_err`. It also pulses `err_irq` for one cycle, puts 1 on `tx_bit`, and resets the buffer index to 0.
- R7: While `underflow_err` is set, requests give `tx_bit` = 1 and consume no buffer. A one-cycle `err_clr` pulse clears the error.
- R8: With `tx_en` low, an active transmitter keeps sending until both status bytes are 0 and the shift register is empty. Only then does it become inactive, and no underflow is flagged.
- R9: A status byte with a nonzero upper nibble, or with a count above 8, is not consumed when requested. `fmt_err` pulses for one cycle, `tx_bit` is 1, and the status byte keeps its value.
- R10: When both buffers are kept full with 8 bytes, `buf_irq` pulses after request 1 and after request 65, and at none of the requests in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host byte write strobe |
| host_addr | input | 5 | Host byte address into the buffer region |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data of the addressed byte |
| tx_en | input | 1 | Transmit enable request |
| bit_req | input | 1 | Modulator request for the next bit |
| tx_bit | output | 1 | Serial transmit bit |
| buf_irq | output | 1 | One-cycle pulse: buffer loaded and emptied |
| err_irq | output | 1 | One-cycle pulse: underflow detected |
| underflow_err | output | 1 | Sticky underflow error |
| err_clr | input | 1 | Clears the underflow error |
| fmt_err | output | 1 | One-cycle pulse: malformed status byte |

## Verification
The assertions check, on every cycle, the properties that hold locally in time. The line idles at 1 while the block is inactive or in error. A buffer-emptied pulse comes with a buffer switch and a cleared status byte. An underflow always leaves the index at buffer 0, and the transmitter becomes inactive only after both status bytes were zero. The bench scenarios cover what needs the whole stream: the exact bit order across buffers of different lengths, the 64-request interrupt spacing, the effect of clearing the error, and the proof that the index went back to buffer 0. It also checks that a delayed stop lets the last buffer finish and that a malformed status byte survives unchanged.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

    typedef enum logic [1:0] {
        STAT_EMPTY = 2'd0,
        STAT_VALID = 2'd1,
        STAT_BAD   = 2'd2
    } stat_kind_e;

    function automatic stat_kind_e classify_status(input logic [7:0] s, input int unsigned max_bytes);
        if (s == 8'h00)
            return STAT_EMPTY;
        if (s[7:4] != 4'h0 || int'(s[3:0]) > max_bytes)
            return STAT_BAD;
        return STAT_VALID;
    endfunction

endpackage

// File: rtl/txbuf_mem.sv
module txbuf_mem #(
    parameter int NBYTES = 8,
    parameter int AW     = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           host_we,
    input  logic [AW-1:0]                  host_addr,
    input  logic [7:0]                     host_wdata,
    output logic [7:0]                     host_rdata,
    input  logic                           clr_en,
    input  logic                           clr_sel,
    output logic [1:0][7:0]                stat_o,
    output logic [1:0][NBYTES-1:0][7:0]    data_o
);
    localparam int STRIDE = NBYTES + 1;

    typedef struct packed {
        logic [1:0][7:0]             stat;
        logic [1:0][NBYTES-1:0][7:0] data;
    } mem_t;

    mem_t mem_d, mem_q;

    always_comb begin
        mem_d      = mem_q;
        host_rdata = 8'h00;
        for (int b = 0; b < 2; b++) begin
            if (int'(host_addr) == b * STRIDE) begin
                host_rdata = mem_q.stat[b];
                if (host_we) mem_d.stat[b] = host_wdata;
            end
            for (int i = 0; i < NBYTES; i++) begin
                if (int'(host_addr) == b * STRIDE + 1 + i) begin
                    host_rdata = mem_q.data[b][i];
                    if (host_we) mem_d.data[b][i] = host_wdata;
                end
            end
        end
        // consumption clear overrides a simultaneous host write
        if (clr_en) mem_d.stat[clr_sel] = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign stat_o = mem_q.stat;
    assign data_o = mem_q.data;

endmodule

// File: rtl/txbuf_core.sv
module txbuf_core
    import txbuf_pkg::*;
#(
    parameter int NBYTES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tx_en,
    input  logic                        bit_req,
    input  logic                        err_clr,
    input  logic [1:0][7:0]             stat_i,
    input  logic [1:0][NBYTES-1:0][7:0] data_i,
    output logic                        clr_en,
    output logic                        clr_sel,
    output logic                        tx_bit,
    output logic                        buf_irq,
    output logic                        err_irq,
    output logic                        underflow_err,
    output logic                        fmt_err
);
    localparam int SHW = NBYTES * 8;
    localparam int CW  = $clog2(SHW + 1);

    typedef struct packed {
        logic           active;
        logic           err;
        logic           idx;
        logic [SHW-1:0] shift;
        logic [CW-1:0]  bits;
        logic           txb;
        logic           buf_irq;
        logic           err_irq;
        logic           fmt_err;
    } core_t;

    core_t      d, q;
    stat_kind_e kind;
    logic [7:0] cur_stat;
    logic       stop_now;

    always_comb begin
        d         = q;
        d.buf_irq = 1'b0;
        d.err_irq = 1'b0;
        d.fmt_err = 1'b0;
        clr_en    = 1'b0;
        clr_sel   = q.idx;
        cur_stat  = stat_i[q.idx];
        kind      = classify_status(cur_stat, NBYTES);
        stop_now  = !tx_en && q.active && stat_i[0] == 8'h00 && stat_i[1] == 8'h00 && q.bits == '0;

        if (tx_en)         d.active = 1'b1;
        else if (stop_now) d.active = 1'b0;
        if (err_clr)       d.err    = 1'b0;

        if (bit_req) begin
            if (!q.active || q.err || stop_now) begin
                d.txb = 1'b1;
            end else if (q.bits != '0) begin
                d.txb   = q.shift[0];
                d.shift = q.shift >> 1;
                d.bits  = q.bits - CW'(1);
            end else begin
                case (kind)
                    STAT_VALID: begin
                        d.txb     = data_i[q.idx][0][0];
                        d.shift   = data_i[q.idx] >> 1;
                        d.bits    = CW'(cur_stat[3:0]) * CW'(8) - CW'(1);
                        d.idx     = ~q.idx;
                        d.buf_irq = 1'b1;
                        clr_en    = 1'b1;
                    end
                    STAT_EMPTY: begin
                        d.err     = 1'b1;
                        d.err_irq = 1'b1;
                        d.idx     = 1'b0;
                        d.txb     = 1'b1;
                    end
                    default: begin
                        d.fmt_err = 1'b1;
                        d.txb     = 1'b1;
                    end
                endcase
            end
        end
        if (!d.active) d.txb = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.txb    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_bit        = q.txb;
    assign buf_irq       = q.buf_irq;
    assign err_irq       = q.err_irq;
    assign underflow_err = q.err;
    assign fmt_err       = q.fmt_err;

    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        !q.active |-> tx_bit) else $error("idle line not at mark");                  // R5
    AST_ERR_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(q.err) && q.err |-> !buf_irq) else $error("load while in error");       // R7
    AST_IRQ_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        buf_irq |-> q.idx != $past(q.idx)) else $error("no buffer switch");           // R4
    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        buf_irq |-> stat_i[$past(q.idx)] == 8'h00) else $error("status not cleared"); // R3
    AST_UNDERFLOW_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> q.idx == 1'b0 && underflow_err && tx_bit) else $error("bad underflow"); // R6
    AST_STOP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.active) |-> $past(stat_i[0] == 8'h00 && stat_i[1] == 8'h00)) else $error("early stop"); // R8
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({buf_irq, err_irq, fmt_err})) else $error("two events at once");     // R9

endmodule

// File: rtl/txbuf_serializer.sv
module txbuf_serializer #(
    parameter int NBYTES = 8,
    localparam int AW    = $clog2(2 * (NBYTES + 1))
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic          tx_en,
    input  logic          bit_req,
    output logic          tx_bit,
    output logic          buf_irq,
    output logic          err_irq,
    output logic          underflow_err,
    input  logic          err_clr,
    output logic          fmt_err
);
    logic [1:0][7:0]             stat_w;
    logic [1:0][NBYTES-1:0][7:0] data_w;
    logic                        clr_en_w;
    logic                        clr_sel_w;

    txbuf_mem #(.NBYTES(NBYTES), .AW(AW)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .clr_en     (clr_en_w),
        .clr_sel    (clr_sel_w),
        .stat_o     (stat_w),
        .data_o     (data_w)
    );

    txbuf_core #(.NBYTES(NBYTES)) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_en         (tx_en),
        .bit_req       (bit_req),
        .err_clr       (err_clr),
        .stat_i        (stat_w),
        .data_i        (data_w),
        .clr_en        (clr_en_w),
        .clr_sel       (clr_sel_w),
        .tx_bit        (tx_bit),
        .buf_irq       (buf_irq),
        .err_irq       (err_irq),
        .underflow_err (underflow_err),
        .fmt_err       (fmt_err)
    );

endmodule

// File: tb/txbuf_serializer_bench.sv
module txbuf_serializer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       tx_en = 1'b0;
    logic       bit_req = 1'b0;
    logic       tx_bit, buf_irq, err_irq, underflow_err, fmt_err;
    logic       err_clr = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txbuf_serializer u_txbuf_serializer (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .tx_en(tx_en),
        .bit_req(bit_req), .tx_bit(tx_bit), .buf_irq(buf_irq), .err_irq(err_irq),
        .underflow_err(underflow_err), .err_clr(err_clr), .fmt_err(fmt_err)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tx_en = 1'b0; bit_req = 1'b0; host_we = 1'b0; err_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_write(input int addr, input logic [7:0] val);
        @(negedge clk);
        host_we = 1'b1; host_addr = 5'(addr); host_wdata = val;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input int addr, output logic [7:0] val);
        @(negedge clk);
        host_addr = 5'(addr);
        #1 val = host_rdata;
    endtask

    // one request; outputs sampled in the cycle after the sampling edge
    task automatic request(output logic b, output logic bi, output logic ei, output logic fe);
        @(negedge clk);
        bit_req = 1'b1;
        @(negedge clk);
        bit_req = 1'b0;
        b = tx_bit; bi = buf_irq; ei = err_irq; fe = fmt_err;
    endtask

    task automatic t_reset_and_map();
        logic [7:0] v;
        do_reset();
        check("R5 reset tx_bit", {7'b0, tx_bit}, 8'h01);
        check("R6 reset underflow_err", {7'b0, underflow_err}, 8'h00);
        host_read(0, v); check("R1 reset status0", v, 8'h00);
        for (int a = 0; a < 18; a++) host_write(a, 8'(8'h30 + a));
        for (int a = 0; a < 18; a++) begin
            host_read(a, v);
            check("R1 readback", v, 8'(8'h30 + a));
        end
    endtask

    task automatic t_disabled();
        logic b, bi, ei, fe;
        logic [7:0] v;
        do_reset();
        host_write(1, 8'h00); host_write(0, 8'h01);
        for (int k = 0; k < 4; k++) begin
            request(b, bi, ei, fe);
            check("R5 disabled mark", {7'b0, b}, 8'h01);
            check("R5 disabled no irq", {7'b0, bi}, 8'h00);
        end
        host_read(0, v); check("R5 status kept while disabled", v, 8'h01);
    endtask

    task automatic t_stream();
        logic b, bi, ei, fe;
        logic [7:0] v;
        logic [23:0] exp_bits;
        do_reset();
        host_write(1, 8'hA5); host_write(2, 8'h3C); host_write(0, 8'h02);
        host_write(10, 8'h81); host_write(9, 8'h01);
        exp_bits = {8'h81, 8'h3C, 8'hA5};
        tx_en = 1'b1;
        for (int k = 0; k < 24; k++) begin
            request(b, bi, ei, fe);
            check("R2 stream bit", {7'b0, b}, {7'b0, exp_bits[k]});
            check("R3 buf_irq timing", {7'b0, bi}, (k == 0 || k == 16) ? 8'h01 : 8'h00);
            if (k == 0) begin
                host_read(0, v); check("R3 status0 cleared", v, 8'h00);
                host_read(9, v); check("R4 status1 untouched", v, 8'h01);
            end
            if (k == 16) begin
                host_read(9, v); check("R4 status1 consumed second", v, 8'h00);
            end
        end
        tx_en = 1'b0;
    endtask

    task automatic t_underflow();
        logic b, bi, ei, fe;
        logic [7:0] v;
        do_reset();
        host_write(1, 8'hFF); host_write(0, 8'h01);
        tx_en = 1'b1;
        for (int k = 0; k < 8; k++) request(b, bi, ei, fe);
        request(b, bi, ei, fe);
        check("R6 underflow flag", {7'b0, underflow_err}, 8'h01);
        check("R6 err_irq pulse", {7'b0, ei}, 8'h01);
        check("R6 mark on underflow", {7'b0, b}, 8'h01);
        @(negedge clk);
        check("R6 err_irq one cycle", {7'b0, err_irq}, 8'h00);
        host_write(10, 8'h00); host_write(9, 8'h01);
        request(b, bi, ei, fe);
        check("R7 mark in error", {7'b0, b}, 8'h01);
        check("R7 no load in error", {7'b0, bi}, 8'h00);
        host_read(9, v); check("R7 status1 kept in error", v, 8'h01);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        check("R7 error cleared", {7'b0, underflow_err}, 8'h00);
        host_write(1, 8'h02); host_write(0, 8'h01);
        request(b, bi, ei, fe);
        check("R6 index back at 0 bit", {7'b0, b}, 8'h00);
        host_read(0, v); check("R6 buffer0 consumed", v, 8'h00);
        host_read(9, v); check("R6 buffer1 still full", v, 8'h01);
        request(b, bi, ei, fe);
        check("R2 second bit after recovery", {7'b0, b}, 8'h01);
        tx_en = 1'b0;
    endtask

    task automatic t_format();
        logic b, bi, ei, fe;
        logic [7:0] v;
        do_reset();
        host_write(0, 8'h12);
        tx_en = 1'b1;
        request(b, bi, ei, fe);
        check("R9 fmt_err upper nibble", {7'b0, fe}, 8'h01);
        check("R9 mark on bad status", {7'b0, b}, 8'h01);
        host_read(0, v); check("R9 status kept", v, 8'h12);
        host_write(0, 8'h09);
        request(b, bi, ei, fe);
        check("R9 fmt_err count above 8", {7'b0, fe}, 8'h01);
        check("R9 no load", {7'b0, bi}, 8'h00);
        check("R9 no underflow", {7'b0, underflow_err}, 8'h00);
        tx_en = 1'b0;
    endtask

    task automatic t_stop();
        logic b, bi, ei, fe;
        do_reset();
        host_write(1, 8'h00); host_write(0, 8'h01);
        host_write(10, 8'h00); host_write(9, 8'h01);
        tx_en = 1'b1;
        request(b, bi, ei, fe);
        tx_en = 1'b0;
        for (int k = 1; k < 16; k++) begin
            request(b, bi, ei, fe);
            check("R8 data continues after stop request", {7'b0, b}, 8'h00);
        end
        request(b, bi, ei, fe);
        check("R8 idle after drain", {7'b0, b}, 8'h01);
        check("R8 no underflow on stop", {7'b0, underflow_err}, 8'h00);
    endtask

    task automatic t_period();
        logic b, bi, ei, fe;
        int irq_count;
        do_reset();
        for (int i = 0; i < 8; i++) begin
            host_write(1 + i, 8'hAA);
            host_write(10 + i, 8'h55);
        end
        host_write(0, 8'h08); host_write(9, 8'h08);
        tx_en = 1'b1;
        irq_count = 0;
        for (int k = 0; k < 65; k++) begin
            request(b, bi, ei, fe);
            if (k == 0 || k == 64) check("R10 irq at buffer start", {7'b0, bi}, 8'h01);
            else if (bi) irq_count++;
            if (k < 64) check("R2 full buffer bit", {7'b0, b}, {7'b0, 1'(k % 2)});
        end
        check("R10 no irq inside buffer", 8'(irq_count), 8'h00);
        tx_en = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset_and_map();
        t_disabled();
        t_stream();
        t_underflow();
        t_format();
        t_stop();
        t_period();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule